// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block sits between a host and an asynchronous parallel NOR flash with a 16-bit data bus. The host hands over one request at a time on a valid/ready handshake: a plain read, a single-word program, a sector erase, a whole-array erase, a software reset, or a buffered program of up to 32 words. For each request the block plays the unlock writes and command writes that the flash expects. It then reads the status word again and again until the flash's internal operation settles, gives up, or runs past a limit set by the host. The outcome is reported as a one-cycle done or error pulse.

The flash strobes are all active low. Address setup, write-enable pulse width, data hold, read access time and the idle gap between bus cycles are each a whole number of clocks, set by parameters. During a buffered program the block does not store the words. It shows the index of the word it needs on `wd_idx`, and the host answers in the same cycle on `wd_in`. A finished embedded operation is checked with one more read, which is compared against the value that should now be in the array.

Top module: `nor_cmd_seq`

## Requirements
- R1: Every request with op code 1, 2, 3 or 5 begins with two writes: 00AAh to address 555h, then 0055h to address 2AAh.
- R2: Program (op code 1) writes 00A0h to 555h after the unlock pair, then writes `req_data` to `req_addr`, then polls.
- R3: Sector erase (op code 2) writes, in order: the unlock pair, 0080h to 555h, the unlock pair again, then 0030h to `req_addr`.
- R4: Whole-array erase (op code 3) follows the same six writes as R3, except that the last one is 0010h to 555h.
- R5: Buffered program (op code 5) writes, after the unlock pair: 0025h to `req_addr`; N-1 to `req_addr`; word i (taken from `wd_in` while `wd_idx` = i) to `req_addr`+i for i from 0 to N-1; and finally 0029h to `req_addr`. N is `req_count`.
- R6: A request is refused with an error pulse one cycle after acceptance, and with no bus cycle at all, if any of these holds: op code 6 or 7; op code 5 with `req_count` of 0; op code 5 with `req_count` above 32; op code 5 where the words would cross a 32-word aligned page (`req_addr` mod 32 plus N above 32).
- R7: After the last command write, status reads are taken at `req_addr`. The operation is complete at the first status read whose bit 6 equals bit 6 of the status read just before it.
- R8: After completion, one verify read is taken and compared with the expected word. Program: `req_data` at `req_addr`. Buffered program: the last word at `req_addr`+N-1. Either erase: FFFFh at `req_addr`. A match gives done; a mismatch gives error.
- R9: A status read that does not complete the operation and has bit 5 set ends polling. The block then writes 00F0h to address 0 and reports error.
- R10: If `poll_limit` status reads (at least one) pass without completion, the block writes 00F0h to address 0 and reports error.
- R11: Reset (op code 4) is a single write of 00F0h to address 0, followed by done with no status read.
- R12: Read (op code 0) is one read cycle at `req_addr`. The word read appears on `rd_data` together with done, and is held there until the next read.
- R13: In each write cycle, write enable stays low for exactly T_WE clocks, chip enable is low and output enable is high for the whole cycle, and the data bus is driven. Address and write data do not change while chip enable is low.
- R14: `req_ready` is high only when the block is idle. It drops in the cycle after a request is accepted and rises again in the cycle after the done or error pulse. Done and error are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to take a request |
| req_op | input | 3 | 0 read, 1 program, 2 sector erase, 3 array erase, 4 reset, 5 buffered program |
| req_addr | input | AW | Word address of the target, sector or first buffered word |
| req_data | input | 16 | Word to program (op code 1) |
| req_count | input | $clog2(BUF_WORDS)+1 | Number of buffered words N (op code 5) |
| poll_limit | input | TW | Maximum number of status reads |
| wd_idx | output | $clog2(BUF_WORDS) | Index of the buffered word requested |
| wd_in | input | 16 | Buffered word for `wd_idx`, driven in the same cycle |
| done | output | 1 | One-cycle pulse: request finished successfully |
| error | output | 1 | One-cycle pulse: request refused or failed |
| rd_data | output | 16 | Word from the last read request |
| fl_addr | output | AW | Flash address bus |
| fl_dq_o | output | 16 | Data driven toward the flash |
| fl_dq_oe | output | 1 | Output enable for the flash data bus |
| fl_dq_i | input | 16 | Data returned by the flash |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_we_n | output | 1 | Flash write enable, active low |

## Verification
The hard cases are the ones where the flash itself misbehaves. Examples are bit 5 rising while bit 6 is still toggling, a status word that never settles before the read limit, or a toggle that settles on a word that fails the verify read. A real array does not produce these on demand. The bench therefore stands in for the flash with a scripted status source indexed by read number. Each request sets how many reads toggle, whether bit 5 rises from the third read on, and whether the settled word is corrupted. The expected number of status reads and the expected outcome are then worked out by the bench from the rules alone.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

  localparam logic [2:0] OP_READ   = 3'd0;
  localparam logic [2:0] OP_PROG   = 3'd1;
  localparam logic [2:0] OP_SERASE = 3'd2;
  localparam logic [2:0] OP_CERASE = 3'd3;
  localparam logic [2:0] OP_RESET  = 3'd4;
  localparam logic [2:0] OP_BUF    = 3'd5;

  typedef enum logic [2:0] {
    PH_IDLE, PH_SETUP, PH_PULSE, PH_HOLD, PH_ACC, PH_GAP
  } phase_e;

  typedef enum logic [2:0] {
    S_IDLE, S_CMD, S_POLL, S_VERIFY, S_RECOVER, S_READ, S_FIN
  } seq_e;

  function automatic int maxi(int a, int b);
    return (a > b) ? a : b;
  endfunction

  // number of write cycles in the command phase of an operation
  function automatic logic [7:0] seq_len(logic [2:0] op, logic [7:0] cnt);
    case (op)
      OP_PROG:              return 8'd4;
      OP_SERASE, OP_CERASE: return 8'd6;
      OP_RESET:             return 8'd1;
      OP_BUF:               return cnt + 8'd5;
      default:              return 8'd0;
    endcase
  endfunction

  // address of command write number 'step'
  function automatic logic [31:0] seq_addr(logic [2:0] op, logic [7:0] step,
                                           logic [31:0] base, logic [7:0] cnt);
    if (op == OP_RESET) return 32'h0;
    if (step == 8'd0 || step == 8'd2) begin
      return (op == OP_BUF) && (step == 8'd2) ? base : 32'h555;
    end
    if (step == 8'd1) return 32'h2AA;
    case (op)
      OP_PROG: return base;
      OP_SERASE, OP_CERASE: begin
        if (step == 8'd3) return 32'h555;
        if (step == 8'd4) return 32'h2AA;
        return (op == OP_SERASE) ? base : 32'h555;
      end
      OP_BUF: begin
        if (step == 8'd3 || step == cnt + 8'd4) return base;
        return base + 32'(step - 8'd4);
      end
      default: return 32'h0;
    endcase
  endfunction

  // data of command write number 'step'
  function automatic logic [15:0] seq_data(logic [2:0] op, logic [7:0] step,
                                           logic [15:0] pdata, logic [7:0] cnt,
                                           logic [15:0] wd);
    if (op == OP_RESET) return 16'h00F0;
    if (step == 8'd0) return 16'h00AA;
    if (step == 8'd1) return 16'h0055;
    case (op)
      OP_PROG: return (step == 8'd2) ? 16'h00A0 : pdata;
      OP_SERASE, OP_CERASE: begin
        if (step == 8'd2) return 16'h0080;
        if (step == 8'd3) return 16'h00AA;
        if (step == 8'd4) return 16'h0055;
        return (op == OP_SERASE) ? 16'h0030 : 16'h0010;
      end
      OP_BUF: begin
        if (step == 8'd2) return 16'h0025;
        if (step == 8'd3) return {8'h00, cnt - 8'd1};
        if (step == cnt + 8'd4) return 16'h0029;
        return wd;
      end
      default: return 16'h0000;
    endcase
  endfunction

endpackage

// File: rtl/nor_bus_cycle.sv
module nor_bus_cycle
  import nor_seq_pkg::*;
#(
  parameter int AW      = 26,
  parameter int T_SETUP = 2,
  parameter int T_WE    = 3,
  parameter int T_HOLD  = 1,
  parameter int T_RD    = 3,
  parameter int T_GAP   = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          is_wr,
  input  logic [AW-1:0] addr,
  input  logic [15:0]   wdata,
  output logic          cyc_done,
  output logic [15:0]   rdata,
  output logic [AW-1:0] fl_addr,
  output logic [15:0]   fl_dq_o,
  output logic          fl_dq_oe,
  input  logic [15:0]   fl_dq_i,
  output logic          fl_ce_n,
  output logic          fl_oe_n,
  output logic          fl_we_n
);
  localparam int TMAX = maxi(maxi(maxi(T_SETUP, T_WE), maxi(T_HOLD, T_RD)), T_GAP);
  localparam int CW   = $clog2(TMAX + 1);

  phase_e        ph;
  logic [CW-1:0] cnt;
  logic [AW-1:0] a_q;
  logic [15:0]   d_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph    <= PH_IDLE;
      cnt   <= '0;
      a_q   <= '0;
      d_q   <= '0;
      rdata <= '0;
    end else if (ph == PH_IDLE) begin
      if (start) begin
        a_q <= addr;
        d_q <= is_wr ? wdata : 16'h0000;
        ph  <= is_wr ? PH_SETUP : PH_ACC;
        cnt <= is_wr ? CW'(T_SETUP - 1) : CW'(T_RD - 1);
      end
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end else begin
      case (ph)
        PH_SETUP: begin ph <= PH_PULSE; cnt <= CW'(T_WE - 1);   end
        PH_PULSE: begin ph <= PH_HOLD;  cnt <= CW'(T_HOLD - 1); end
        PH_HOLD:  begin ph <= PH_GAP;   cnt <= CW'(T_GAP - 1);  end
        PH_ACC: begin
          rdata <= fl_dq_i;
          ph    <= PH_GAP;
          cnt   <= CW'(T_GAP - 1);
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  assign cyc_done = (ph == PH_GAP) && (cnt == '0);
  assign fl_addr  = a_q;
  assign fl_dq_o  = d_q;
  assign fl_dq_oe = (ph == PH_SETUP) || (ph == PH_PULSE) || (ph == PH_HOLD);
  assign fl_ce_n  = !(fl_dq_oe || (ph == PH_ACC));
  assign fl_oe_n  = (ph != PH_ACC);
  assign fl_we_n  = (ph != PH_PULSE);

endmodule

// File: rtl/nor_poll_eval.sv
module nor_poll_eval #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          sample,
  input  logic          dq6,
  input  logic          dq5,
  input  logic [TW-1:0] limit,
  output logic          complete,
  output logic          stat_abort,
  output logic          limit_abort
);
  logic          first_q;
  logic          prev6_q;
  logic [TW-1:0] cnt_q;

  assign complete    = sample && !first_q && (dq6 == prev6_q);
  assign stat_abort  = sample && !complete && dq5;
  assign limit_abort = sample && !complete && !dq5 &&
                       (({1'b0, cnt_q} + 1'b1) >= {1'b0, limit});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= 1'b1;
      prev6_q <= 1'b0;
      cnt_q   <= '0;
    end else if (clear) begin
      first_q <= 1'b1;
      cnt_q   <= '0;
    end else if (sample) begin
      first_q <= 1'b0;
      prev6_q <= dq6;
      cnt_q   <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
  import nor_seq_pkg::*;
#(
  parameter int AW        = 26,
  parameter int BUF_WORDS = 32,
  parameter int TW        = 16,
  parameter int T_SETUP   = 2,
  parameter int T_WE      = 3,
  parameter int T_HOLD    = 1,
  parameter int T_RD      = 3,
  parameter int T_GAP     = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  output logic                         req_ready,
  input  logic [2:0]                   req_op,
  input  logic [AW-1:0]                req_addr,
  input  logic [15:0]                  req_data,
  input  logic [$clog2(BUF_WORDS):0]   req_count,
  input  logic [TW-1:0]                poll_limit,
  output logic [$clog2(BUF_WORDS)-1:0] wd_idx,
  input  logic [15:0]                  wd_in,
  output logic                         done,
  output logic                         error,
  output logic [15:0]                  rd_data,
  output logic [AW-1:0]                fl_addr,
  output logic [15:0]                  fl_dq_o,
  output logic                         fl_dq_oe,
  input  logic [15:0]                  fl_dq_i,
  output logic                         fl_ce_n,
  output logic                         fl_oe_n,
  output logic                         fl_we_n
);
  localparam int WIDX = $clog2(BUF_WORDS);
  localparam int CNTW = WIDX + 1;

  function automatic logic buf_ok(logic [AW-1:0] a, logic [CNTW-1:0] c);
    int off;
    off = int'(a[WIDX-1:0]);
    return (c != '0) && (int'(c) <= BUF_WORDS) && (off + int'(c) <= BUF_WORDS);
  endfunction

  seq_e          st;
  logic [2:0]    op_q;
  logic [AW-1:0] addr_q;
  logic [15:0]   data_q;
  logic [7:0]    cnt_q;
  logic [7:0]    step_q;
  logic          go_q;
  logic          err_q;
  logic [15:0]   last_wd_q;
  logic [15:0]   rd_q;

  // named internal events
  logic          cyc_done;
  logic [15:0]   bus_rdata;
  logic          bus_is_wr;
  logic [AW-1:0] bus_addr;
  logic [15:0]   bus_wdata;
  logic          cmd_last;
  logic          poll_clear;
  logic          poll_sample;
  logic          poll_complete;
  logic          poll_stat_abort;
  logic          poll_limit_abort;
  logic          req_fire;
  logic          reject_evt;
  logic [AW-1:0] verify_addr;
  logic [15:0]   verify_exp;

  assign req_ready   = (st == S_IDLE);
  assign req_fire    = req_valid && req_ready;
  assign reject_evt  = req_fire && (req_op != OP_READ) &&
                       ((req_op > OP_BUF) || ((req_op == OP_BUF) && !buf_ok(req_addr, req_count)));
  assign cmd_last    = (step_q == seq_len(op_q, cnt_q) - 8'd1);
  assign poll_clear  = (st == S_CMD) && cyc_done && cmd_last && (op_q != OP_RESET);
  assign poll_sample = (st == S_POLL) && cyc_done;
  assign wd_idx      = WIDX'(step_q - 8'd4);
  assign verify_addr = (op_q == OP_BUF) ? addr_q + AW'(cnt_q) - 1'b1 : addr_q;
  assign verify_exp  = (op_q == OP_BUF)  ? last_wd_q :
                       (op_q == OP_PROG) ? data_q : 16'hFFFF;
  assign done        = (st == S_FIN) && !err_q;
  assign error       = (st == S_FIN) && err_q;
  assign rd_data     = rd_q;

  always_comb begin
    bus_is_wr = 1'b0;
    bus_addr  = addr_q;
    bus_wdata = 16'h0000;
    case (st)
      S_CMD: begin
        bus_is_wr = 1'b1;
        bus_addr  = AW'(seq_addr(op_q, step_q, 32'(addr_q), cnt_q));
        bus_wdata = seq_data(op_q, step_q, data_q, cnt_q, wd_in);
      end
      S_RECOVER: begin
        bus_is_wr = 1'b1;
        bus_addr  = '0;
        bus_wdata = 16'h00F0;
      end
      S_VERIFY: bus_addr = verify_addr;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      op_q      <= OP_READ;
      addr_q    <= '0;
      data_q    <= '0;
      cnt_q     <= '0;
      step_q    <= '0;
      go_q      <= 1'b0;
      err_q     <= 1'b0;
      last_wd_q <= '0;
      rd_q      <= '0;
    end else begin
      go_q <= 1'b0;
      case (st)
        S_IDLE: if (req_fire) begin
          op_q   <= req_op;
          addr_q <= req_addr;
          data_q <= req_data;
          cnt_q  <= 8'(req_count);
          step_q <= '0;
          err_q  <= reject_evt;
          if (reject_evt) begin
            st <= S_FIN;
          end else begin
            st   <= (req_op == OP_READ) ? S_READ : S_CMD;
            go_q <= 1'b1;
          end
        end
        S_CMD: begin
          if (go_q && (op_q == OP_BUF) && (step_q == cnt_q + 8'd3)) last_wd_q <= wd_in;
          if (cyc_done) begin
            go_q <= !(cmd_last && (op_q == OP_RESET));
            if (!cmd_last)              step_q <= step_q + 8'd1;
            else if (op_q == OP_RESET)  st <= S_FIN;
            else                        st <= S_POLL;
          end
        end
        S_POLL: if (cyc_done) begin
          go_q <= 1'b1;
          if (poll_complete) st <= S_VERIFY;
          else if (poll_stat_abort || poll_limit_abort) begin
            st    <= S_RECOVER;
            err_q <= 1'b1;
          end
        end
        S_VERIFY: if (cyc_done) begin
          err_q <= (bus_rdata != verify_exp);
          st    <= S_FIN;
        end
        S_RECOVER: if (cyc_done) st <= S_FIN;
        S_READ: if (cyc_done) begin
          rd_q <= bus_rdata;
          st   <= S_FIN;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  nor_bus_cycle #(
    .AW(AW), .T_SETUP(T_SETUP), .T_WE(T_WE), .T_HOLD(T_HOLD),
    .T_RD(T_RD), .T_GAP(T_GAP)
  ) u_bus (
    .clk(clk), .rst_n(rst_n), .start(go_q), .is_wr(bus_is_wr),
    .addr(bus_addr), .wdata(bus_wdata), .cyc_done(cyc_done), .rdata(bus_rdata),
    .fl_addr(fl_addr), .fl_dq_o(fl_dq_o), .fl_dq_oe(fl_dq_oe), .fl_dq_i(fl_dq_i),
    .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n)
  );

  nor_poll_eval #(.TW(TW)) u_poll (
    .clk(clk), .rst_n(rst_n), .clear(poll_clear), .sample(poll_sample),
    .dq6(bus_rdata[6]), .dq5(bus_rdata[5]), .limit(poll_limit),
    .complete(poll_complete), .stat_abort(poll_stat_abort),
    .limit_abort(poll_limit_abort)
  );

endmodule

// File: rtl/nor_seq_chk.sv
module nor_seq_chk #(
  parameter int AW   = 26,
  parameter int T_WE = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fl_ce_n,
  input logic          fl_oe_n,
  input logic          fl_we_n,
  input logic          fl_dq_oe,
  input logic [AW-1:0] fl_addr,
  input logic [15:0]   fl_dq_o,
  input logic          req_valid,
  input logic          req_ready,
  input logic          done,
  input logic          error,
  input logic          reject_evt
);
  logic [15:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        low_cnt <= '0;
    else if (!fl_we_n) low_cnt <= low_cnt + 1'b1;
    else               low_cnt <= '0;
  end

  a_r13_we_inside_ce: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_we_n |-> (!fl_ce_n && fl_oe_n && fl_dq_oe));

  a_r13_bus_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (!fl_ce_n && $past(!fl_ce_n)) |-> ($stable(fl_addr) && $stable(fl_dq_o)));

  a_r13_we_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_we_n) |-> (low_cnt == 16'(T_WE)));

  a_r14_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error));

  a_r14_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  a_r14_ready_after_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    (done || error) |=> req_ready);

  a_r6_reject_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    reject_evt |=> (error && fl_ce_n));

endmodule

bind nor_cmd_seq nor_seq_chk #(.AW(AW), .T_WE(T_WE)) u_chk (
  .clk(clk), .rst_n(rst_n), .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n),
  .fl_we_n(fl_we_n), .fl_dq_oe(fl_dq_oe), .fl_addr(fl_addr), .fl_dq_o(fl_dq_o),
  .req_valid(req_valid), .req_ready(req_ready), .done(done), .error(error),
  .reject_evt(reject_evt)
);

// File: tb/tb_nor_cmd_seq.sv
`timescale 1ns/1ps
module tb_nor_cmd_seq;
  localparam int AW  = 16;
  localparam int TWE = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_op = '0;
  logic [15:0] req_addr = '0;
  logic [15:0] req_data = '0;
  logic [5:0]  req_count = '0;
  logic [15:0] poll_limit = 16'd8;
  logic [4:0]  wd_idx;
  logic [15:0] wd_in;
  logic        done, error;
  logic [15:0] rd_data;
  logic [15:0] fl_addr, fl_dq_o, fl_dq_i;
  logic        fl_dq_oe, fl_ce_n, fl_oe_n, fl_we_n;

  int checks = 0, failures = 0;

  // scripted flash stand-in
  logic        log_on = 1'b0;
  logic        plain = 1'b0;
  int          scen_t = 0;
  logic        scen_fail = 1'b0;
  logic [15:0] scen_final = '0;
  logic [15:0] salt = '0;
  int          rd_k = 0;
  int          wn = 0, rn = 0, we_bad = 0;
  logic [15:0] wla [64];
  logic [15:0] wld [64];
  logic [15:0] rla [64];
  logic [15:0] ea [64];
  logic [15:0] ed [64];
  int          en;
  time         t_fall;

  always #5 clk = ~clk;

  function automatic logic [15:0] bw(logic [4:0] i, logic [15:0] s);
    return (16'h1000 + 16'(i) * 16'h0137) ^ s;
  endfunction
  function automatic logic [15:0] rdw(logic [15:0] a);
    return (a * 16'h9E37) ^ 16'hC3A5;
  endfunction
  function automatic logic [15:0] stat(int k, int t, logic f, logic [15:0] fin);
    logic [15:0] w;
    if (k >= t) return fin;
    w = 16'h0000;
    w[6] = k[0];
    w[5] = f && (k >= 2);
    return w;
  endfunction

  assign wd_in   = bw(wd_idx, salt);
  assign fl_dq_i = plain ? rdw(fl_addr) : stat(rd_k, scen_t, scen_fail, scen_final);

  always @(negedge fl_we_n) begin
    t_fall = $time;
    if (log_on && (fl_ce_n !== 1'b0 || fl_oe_n !== 1'b1 || fl_dq_oe !== 1'b1)) we_bad++;
  end
  always @(posedge fl_we_n) if (log_on && rst_n) begin
    if ($time - t_fall != TWE * 10) we_bad++;
    if (wn < 64) begin wla[wn] = fl_addr; wld[wn] = fl_dq_o; end
    wn++;
  end
  always @(posedge fl_oe_n) if (log_on && rst_n) begin
    if (rn < 64) rla[rn] = fl_addr;
    rn++;
    rd_k++;
  end

  nor_cmd_seq #(.AW(AW), .T_WE(TWE)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_data(req_data), .req_count(req_count),
    .poll_limit(poll_limit), .wd_idx(wd_idx), .wd_in(wd_in), .done(done),
    .error(error), .rd_data(rd_data), .fl_addr(fl_addr), .fl_dq_o(fl_dq_o),
    .fl_dq_oe(fl_dq_oe), .fl_dq_i(fl_dq_i), .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n),
    .fl_we_n(fl_we_n)
  );

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [15:0] a, input logic [15:0] d);
    ea[en] = a; ed[en] = d; en++;
  endtask

  task automatic run_op(input logic [2:0] op, input logic [15:0] a, input logic [15:0] d,
                        input int c, input int t, input logic f, input int lim,
                        input logic corrupt);
    logic [15:0] expv, vaddr;
    logic        bufv, polls, got_done, exp_done, ok1;
    int          exp_reads, k, n;
    logic        prev6;
    logic [15:0] w;
    string       rq;
    bufv  = (c >= 1) && (c <= 32) && ((int'(a) % 32) + c <= 32);
    salt  = 16'($urandom);
    expv  = (op == 3'd5) ? bw(5'(c - 1), salt) : (op == 3'd1) ? d : 16'hFFFF;
    vaddr = (op == 3'd5) ? a + 16'(c - 1) : a;
    scen_t = t; scen_fail = f; scen_final = corrupt ? expv ^ 16'h0001 : expv;
    plain = (op == 3'd0);
    en = 0; exp_reads = 0; polls = 1'b0; exp_done = 1'b1;
    case (op)
      3'd0: begin rq = "R12"; exp_reads = 1; end
      3'd1: begin rq = "R2"; push(16'h555,16'hAA); push(16'h2AA,16'h55);
              push(16'h555,16'hA0); push(a,d); polls = 1'b1; end
      3'd2, 3'd3: begin rq = (op == 3'd2) ? "R3" : "R4";
              push(16'h555,16'hAA); push(16'h2AA,16'h55); push(16'h555,16'h80);
              push(16'h555,16'hAA); push(16'h2AA,16'h55);
              if (op == 3'd2) push(a,16'h30); else push(16'h555,16'h10);
              polls = 1'b1; end
      3'd4: begin rq = "R11"; push(16'h0,16'hF0); end
      3'd5: begin
              rq = bufv ? "R5" : "R6";
              if (bufv) begin
                push(16'h555,16'hAA); push(16'h2AA,16'h55); push(a,16'h25);
                push(a,16'(c - 1));
                for (int i = 0; i < c; i++) push(a + 16'(i), bw(5'(i), salt));
                push(a,16'h29); polls = 1'b1;
              end else exp_done = 1'b0;
            end
      default: begin rq = "R6"; exp_done = 1'b0; end
    endcase
    if (polls) begin
      prev6 = 1'b0;
      for (k = 0; k < 1000; k++) begin
        w = stat(k, t, f, scen_final);
        exp_reads++;
        if (k > 0 && w[6] == prev6) begin
          exp_reads++;
          exp_done = (stat(k + 1, t, f, scen_final) == expv);
          break;
        end
        if (w[5] || (k + 1 >= lim)) begin
          push(16'h0, 16'hF0); exp_done = 1'b0; break;
        end
        prev6 = w[6];
      end
    end
    wn = 0; rn = 0; rd_k = 0; log_on = 1'b1;
    poll_limit = 16'(lim);
    @(negedge clk);
    chk(req_ready, "R14", "ready before request", {31'b0, req_ready}, 1);
    req_valid = 1'b1; req_op = op; req_addr = a; req_data = d; req_count = 6'(c);
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R14", "ready low after accept", {31'b0, req_ready}, 0);
    n = 0;
    while (!(done || error) && n < 20000) begin @(negedge clk); n++; end
    got_done = done;
    chk(!(done && error), "R14", "done and error together", {30'b0, done, error}, 2);
    @(negedge clk);
    chk(req_ready, "R14", "ready back after outcome", {31'b0, req_ready}, 1);
    log_on = 1'b0;
    chk(got_done == exp_done, rq, "outcome done", {31'b0, got_done}, {31'b0, exp_done});
    chk(wn == en, rq, "write count", wn, en);
    ok1 = 1'b1;
    for (int i = 0; i < en && i < wn; i++)
      if (wla[i] !== ea[i] || wld[i] !== ed[i]) begin
        if (ok1) chk(1'b0, rq, "write addr/data", {wla[i], wld[i]}, {ea[i], ed[i]});
        ok1 = 1'b0;
      end
    if (ok1) chk(1'b1, rq, "write sequence", 0, 0);
    if (op >= 3'd1 && op <= 3'd5 && op != 3'd4 && en >= 2)
      chk(wla[0] == 16'h555 && wld[0] == 16'hAA && wla[1] == 16'h2AA && wld[1] == 16'h55,
          "R1", "unlock pair", {wld[0], wld[1]}, 32'h00AA0055);
    chk(rn == exp_reads, polls ? "R7" : rq, "read count", rn, exp_reads);
    if (polls && rn == exp_reads && rn > 0) begin
      ok1 = 1'b1;
      for (int i = 0; i < rn; i++) begin
        logic [15:0] want;
        want = (exp_done || (i < rn - 1) || wn > en - 1) ? a : a;
        if (i == rn - 1 && en > 0 && ed[en-1] != 16'hF0) want = vaddr;
        if (rla[i] !== want) ok1 = 1'b0;
      end
      chk(ok1, "R8", "status/verify read addresses", rla[rn-1], vaddr);
    end
    if (op == 3'd0)
      chk(rd_data == rdw(a), "R12", "read data", rd_data, rdw(a));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd7321);
    repeat (3) @(negedge clk);
    chk(req_ready && fl_ce_n && fl_we_n && fl_oe_n && !done && !error, "R14",
        "reset state", {26'b0, req_ready, fl_ce_n, fl_we_n, fl_oe_n, done, error}, 6'b111100);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // directed corners
    run_op(3'd0, 16'h1234, 16'h0, 0, 0, 1'b0, 8, 1'b0);   // R12 read
    run_op(3'd1, 16'h0420, 16'hBEEF, 0, 5, 1'b0, 20, 1'b0); // R2 program
    run_op(3'd1, 16'h0421, 16'h1357, 0, 0, 1'b0, 20, 1'b0); // R7 settles at once
    run_op(3'd2, 16'h8000, 16'h0, 0, 7, 1'b0, 20, 1'b0);  // R3
    run_op(3'd3, 16'h0000, 16'h0, 0, 9, 1'b0, 20, 1'b0);  // R4
    run_op(3'd4, 16'h4444, 16'h0, 0, 0, 1'b0, 8, 1'b0);   // R11
    run_op(3'd5, 16'h0200, 16'h0, 32, 4, 1'b0, 20, 1'b0); // R5 full page
    run_op(3'd5, 16'h021F, 16'h0, 1, 3, 1'b0, 20, 1'b0);  // R5 last slot
    run_op(3'd5, 16'h0210, 16'h0, 17, 3, 1'b0, 20, 1'b0); // R6 crosses page
    run_op(3'd5, 16'h0200, 16'h0, 0, 3, 1'b0, 20, 1'b0);  // R6 zero count
    run_op(3'd5, 16'h0200, 16'h0, 33, 3, 1'b0, 20, 1'b0); // R6 too many
    run_op(3'd6, 16'h0200, 16'h0, 0, 3, 1'b0, 20, 1'b0);  // R6 bad op
    run_op(3'd7, 16'h0200, 16'h0, 0, 3, 1'b0, 20, 1'b0);  // R6 bad op
    run_op(3'd1, 16'h0300, 16'h5555, 0, 12, 1'b1, 20, 1'b0); // R9 bit 5
    run_op(3'd2, 16'h0300, 16'h0, 0, 12, 1'b0, 4, 1'b0);  // R10 limit
    run_op(3'd1, 16'h0300, 16'hAAAA, 0, 6, 1'b0, 1, 1'b0); // R10 limit of one
    run_op(3'd1, 16'h0310, 16'h0F0F, 0, 6, 1'b0, 20, 1'b1); // R8 mismatch
    run_op(3'd5, 16'h0340, 16'h0, 8, 5, 1'b0, 20, 1'b1);  // R8 buffer mismatch
    // constrained random
    for (int it = 0; it < 45; it++) begin
      logic [2:0]  op;
      logic [15:0] a;
      int          c;
      op = 3'($urandom % 8);
      a  = 16'($urandom);
      c  = 1 + int'($urandom % 32);
      if (($urandom % 4) != 0) a = (a & 16'hFFE0) + 16'($urandom % (33 - c));
      run_op(op, a, 16'($urandom), c, int'($urandom % 15), ($urandom % 6) == 0,
             2 + int'($urandom % 14), ($urandom % 5) == 0);
    end
    chk(we_bad == 0, "R13", "write strobe width and framing", we_bad, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule